// File: doc/BRIEF.md
# Write-Protected External Memory Pin-Map Register

This block is a control register that decides how a group of shared port pins is used when a controller runs from external memory. One field picks how many upper address lines (A16 and up) leave the chip on the six shared high pins. Those pins carry the matching bits of the external address, and the same choice sets the size of each program chip-enable window. A second field picks how many of the four low pins of the 8-bit port carry chip enables instead of port data. A pin taken for an address line or a chip enable is shielded from ordinary port-latch writes. Firmware can therefore keep writing whole bytes to the port without disturbing the memory interface.

A change to the memory map could crash a running system, so the register takes a write only while a short unlock window is open. Firmware opens the window by writing a two-byte key to a separate key address. The register can be read at any time. The block also decodes a 22-bit external address into four active-low program chip enables, using the window size that the register selects.

Top module: `xmem_pinmap_reg`

## Requirements
- R1: After reset the register reads FFh at SFR address 92h. All six high pins carry address lines, all four chip-enable pins are assigned, and both port latches hold all ones.
- R2: The register can be read at any time. Bits 7:6 are reserved: they always read 1 and writes do not change them. Reading any other SFR address returns 00h.
- R3: A write to address 92h while the unlock window is closed has no effect on the register.
- R4: Writing AAh and then 55h to key address C7h, as two consecutive SFR writes, opens the unlock window. An SFR write to any address between the two cancels the key. The window accepts a register write on any of the 4 clock edges that follow the 55h write, and not on the 5th.
- R5: Bits 5:3 of the register give the address-pin code c. Code c assigns A16 up to A(15+c) for c = 0..5, and codes 6 and 7 both assign A16..A21. hi_pin_is_addr bit k is 1 when line A(16+k) is driven. Bits 0..3 map to P4.4..P4.7 and bits 4..5 map to P6.4..P6.5.
- R6: Bits 2:0 of the register give a code e. Chip enable CEi appears on pin P4.i (ce_pin_en bit i = 1) exactly when e > i.
- R7: The chip-enable window is 2^W bytes. W = 15 for code 0, W = 16 + c for codes 1 to 5, and W = 22 for codes 6 and 7. Code 0 therefore gives 32kB windows, not 64kB.
- R8: ce_n[i] is low exactly when xaddr / 2^W equals i. When that quotient is 4 or more, all four chip enables stay high. At most one chip enable is low at any time.
- R9: Each pin drives its assigned function. An address pin drives its xaddr bit, P4.i with a chip enable drives ce_n[i], and any other pin drives its port-latch bit.
- R10: A port write (port_wr_p4 takes port_wdata[7:0]; port_wr_p6 takes port_wdata[5:4] into P6.5/P6.4) updates only the latch bits of pins that are not locked. A pin is locked while it is assigned to an address line or a chip enable, and its latch bit keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| port_wr_p4 | input | 1 | Byte write to the 8-bit port latch |
| port_wr_p6 | input | 1 | Write to the two shared upper-port latch bits |
| port_wdata | input | 8 | Port write data |
| xaddr | input | 22 | External memory address |
| hi_pin_is_addr | output | 6 | Per high pin: 1 = address line, 0 = I/O |
| ce_pin_en | output | 4 | Per low pin P4.0..P4.3: 1 = chip enable |
| p4_pin_out | output | 8 | Drive value of P4.7..P4.0 |
| p6_pin_out | output | 2 | Drive value of P6.5..P6.4 |
| ce_n | output | 4 | Program chip enables, active low |

## Verification
The bench sweeps all eight address-pin codes. For each code it probes the first and last byte of every chip-enable window, plus the first address above the fourth window. A wrong window width would enable the neighbouring chip enable or none at all at exactly these addresses, and code 0 set to 64kB would fail at 8000h. The unlock window is probed on its 4th and 5th edge, and with a key whose two writes are split by another write. A counter off by one, or a sequencer that ignores the interruption, would let a protected write through. Port writes are made while pins are locked, and then the lock is released through the protected register. The pins then show their latch contents, so a latch that took the write while locked shows up at the port.

// File: rtl/xmem_pinmap_pkg.sv
package xmem_pinmap_pkg;

    localparam int HI_PINS   = 6;
    localparam int CE_PINS   = 4;
    localparam int P4_WIDTH  = 8;
    localparam int P6_SHARED = 2;
    localparam int CFG_BITS  = 6;

    typedef struct packed {
        logic [CFG_BITS-1:0]  cfg;
        logic [P4_WIDTH-1:0]  p4_lat;
        logic [P6_SHARED-1:0] p6_lat;
    } pinmap_regs_t;

endpackage

// File: rtl/xmem_ta_seq.sv
module xmem_ta_seq #(
    parameter logic [7:0] KEY_ADDR    = 8'hC7,
    parameter logic [7:0] KEY_FIRST   = 8'hAA,
    parameter logic [7:0] KEY_SECOND  = 8'h55,
    parameter int         OPEN_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic       open
);
    localparam int CW = $clog2(OPEN_CYCLES + 1);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } ta_state_t;

    ta_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
        if (wr) begin
            st_d.armed = 1'b0;
            if (addr == KEY_ADDR) begin
                if (wdata == KEY_FIRST) begin
                    st_d.armed = 1'b1;
                end else if (wdata == KEY_SECOND && st_q.armed) begin
                    st_d.cnt = CW'(OPEN_CYCLES);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open = (st_q.cnt != '0);

endmodule

// File: rtl/xmem_map_decode.sv
module xmem_map_decode #(
    parameter int HI_PINS    = 6,
    parameter int CE_PINS    = 4,
    parameter int BASE_SHIFT = 15,
    parameter int FIRST_LINE = 16,
    parameter int SHW        = 5
) (
    input  logic [2:0]         hi_code,
    input  logic [2:0]         ce_code,
    output logic [HI_PINS-1:0] hi_is_addr,
    output logic [CE_PINS-1:0] ce_pin_en,
    output logic [SHW-1:0]     win_shift
);
    for (genvar k = 0; k < HI_PINS; k++) begin : g_hi
        assign hi_is_addr[k] = (hi_code > 3'(k));
    end

    for (genvar i = 0; i < CE_PINS; i++) begin : g_ce
        assign ce_pin_en[i] = (ce_code > 3'(i));
    end

    always_comb begin
        if (hi_code == 3'd0) begin
            win_shift = SHW'(BASE_SHIFT);
        end else if (int'(hi_code) >= HI_PINS) begin
            win_shift = SHW'(FIRST_LINE + HI_PINS);
        end else begin
            win_shift = SHW'(FIRST_LINE) + SHW'(hi_code);
        end
    end

endmodule

// File: rtl/xmem_ce_decode.sv
module xmem_ce_decode #(
    parameter int ADDR_W  = 22,
    parameter int CE_PINS = 4,
    parameter int SHW     = 5
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SHW-1:0]     shift,
    output logic [CE_PINS-1:0] ce_n
);
    localparam int SELW = $clog2(CE_PINS);

    logic [ADDR_W-1:0] win_idx;
    logic [SELW-1:0]   sel;
    logic              above;

    assign win_idx = addr >> shift;
    assign sel     = win_idx[SELW-1:0];
    assign above   = |(win_idx >> SELW);

    for (genvar i = 0; i < CE_PINS; i++) begin : g_ce
        assign ce_n[i] = !(!above && sel == SELW'(i));
    end

endmodule

// File: rtl/xmem_pinmap_reg.sv
module xmem_pinmap_reg
    import xmem_pinmap_pkg::*;
#(
    parameter logic [7:0] CFG_ADDR    = 8'h92,
    parameter logic [7:0] KEY_ADDR    = 8'hC7,
    parameter int         OPEN_CYCLES = 4,
    parameter int         ADDR_W      = 22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sfr_wr,
    input  logic [7:0]           sfr_addr,
    input  logic [7:0]           sfr_wdata,
    output logic [7:0]           sfr_rdata,
    input  logic                 port_wr_p4,
    input  logic                 port_wr_p6,
    input  logic [7:0]           port_wdata,
    input  logic [ADDR_W-1:0]    xaddr,
    output logic [HI_PINS-1:0]   hi_pin_is_addr,
    output logic [CE_PINS-1:0]   ce_pin_en,
    output logic [P4_WIDTH-1:0]  p4_pin_out,
    output logic [P6_SHARED-1:0] p6_pin_out,
    output logic [CE_PINS-1:0]   ce_n
);
    localparam int SHW       = $clog2(ADDR_W + 1);
    localparam int FIRST_HI  = 16;
    localparam int P4_HI_CNT = P4_WIDTH - CE_PINS;
    localparam int RSV_BITS  = 8 - CFG_BITS;

    pinmap_regs_t st_d, st_q;

    logic                 ta_open;
    logic                 cfg_wr_ok;
    logic [SHW-1:0]       win_shift;
    logic [P4_WIDTH-1:0]  p4_lock;
    logic [P6_SHARED-1:0] p6_lock;
    logic [CFG_BITS-1:0]  cfg_q;
    logic [P4_WIDTH-1:0]  p4_lat_q;

    xmem_ta_seq #(
        .KEY_ADDR   (KEY_ADDR),
        .OPEN_CYCLES(OPEN_CYCLES)
    ) u_ta (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (sfr_wr),
        .addr (sfr_addr),
        .wdata(sfr_wdata),
        .open (ta_open)
    );

    xmem_map_decode #(
        .HI_PINS   (HI_PINS),
        .CE_PINS   (CE_PINS),
        .BASE_SHIFT(15),
        .FIRST_LINE(FIRST_HI),
        .SHW       (SHW)
    ) u_map (
        .hi_code   (st_q.cfg[5:3]),
        .ce_code   (st_q.cfg[2:0]),
        .hi_is_addr(hi_pin_is_addr),
        .ce_pin_en (ce_pin_en),
        .win_shift (win_shift)
    );

    xmem_ce_decode #(
        .ADDR_W (ADDR_W),
        .CE_PINS(CE_PINS),
        .SHW    (SHW)
    ) u_ce (
        .addr (xaddr),
        .shift(win_shift),
        .ce_n (ce_n)
    );

    assign p4_lock   = {hi_pin_is_addr[P4_HI_CNT-1:0], ce_pin_en};
    assign p6_lock   = hi_pin_is_addr[HI_PINS-1:P4_HI_CNT];
    assign cfg_wr_ok = sfr_wr && (sfr_addr == CFG_ADDR) && ta_open;

    always_comb begin
        st_d = st_q;
        if (cfg_wr_ok) begin
            st_d.cfg = sfr_wdata[CFG_BITS-1:0];
        end
        if (port_wr_p4) begin
            st_d.p4_lat = (port_wdata & ~p4_lock) | (st_q.p4_lat & p4_lock);
        end
        if (port_wr_p6) begin
            st_d.p6_lat = (port_wdata[5:4] & ~p6_lock) | (st_q.p6_lat & p6_lock);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q    = st_q.cfg;
    assign p4_lat_q = st_q.p4_lat;

    assign sfr_rdata = (sfr_addr == CFG_ADDR) ? {{RSV_BITS{1'b1}}, st_q.cfg} : 8'h00;

    for (genvar i = 0; i < CE_PINS; i++) begin : g_p4_lo
        assign p4_pin_out[i] = ce_pin_en[i] ? ce_n[i] : st_q.p4_lat[i];
    end
    for (genvar k = 0; k < P4_HI_CNT; k++) begin : g_p4_hi
        assign p4_pin_out[CE_PINS+k] = hi_pin_is_addr[k] ? xaddr[FIRST_HI+k]
                                                         : st_q.p4_lat[CE_PINS+k];
    end
    for (genvar j = 0; j < P6_SHARED; j++) begin : g_p6
        assign p6_pin_out[j] = hi_pin_is_addr[P4_HI_CNT+j] ? xaddr[FIRST_HI+P4_HI_CNT+j]
                                                           : st_q.p6_lat[j];
    end

endmodule

// File: rtl/xmem_pinmap_chk.sv
module xmem_pinmap_chk #(
    parameter logic [7:0] CFG_ADDR = 8'h92,
    parameter int         HI_PINS  = 6,
    parameter int         CE_PINS  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sfr_wr,
    input logic [7:0]         sfr_addr,
    input logic [7:0]         sfr_rdata,
    input logic               ta_open,
    input logic [5:0]         cfg_q,
    input logic [HI_PINS-1:0] hi_pin_is_addr,
    input logic [CE_PINS-1:0] ce_n,
    input logic               port_wr_p4,
    input logic [7:0]         p4_lat_q
);
    assert_locked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfr_wr && sfr_addr == CFG_ADDR && ta_open) |=> $stable(cfg_q));

    assert_reserved_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == CFG_ADDR) |-> (sfr_rdata[7:6] == 2'b11));

    assert_ce_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));

    assert_contig_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((HI_PINS'(hi_pin_is_addr + HI_PINS'(1)) & hi_pin_is_addr) == '0));

    assert_latch_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr_p4 && hi_pin_is_addr[0]) |=> $stable(p4_lat_q[4]));

endmodule

bind xmem_pinmap_reg xmem_pinmap_chk #(
    .CFG_ADDR(CFG_ADDR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sfr_wr        (sfr_wr),
    .sfr_addr      (sfr_addr),
    .sfr_rdata     (sfr_rdata),
    .ta_open       (ta_open),
    .cfg_q         (cfg_q),
    .hi_pin_is_addr(hi_pin_is_addr),
    .ce_n          (ce_n),
    .port_wr_p4    (port_wr_p4),
    .p4_lat_q      (p4_lat_q)
);

// File: tb/xmem_pinmap_reg_tb.sv
module xmem_pinmap_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] CFG = 8'h92;
    localparam logic [7:0] KEY = 8'hC7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        port_wr_p4 = 1'b0;
    logic        port_wr_p6 = 1'b0;
    logic [7:0]  port_wdata = 8'h00;
    logic [21:0] xaddr = '0;
    logic [5:0]  hi_pin_is_addr;
    logic [3:0]  ce_pin_en;
    logic [7:0]  p4_pin_out;
    logic [1:0]  p6_pin_out;
    logic [3:0]  ce_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    xmem_pinmap_reg u_dut (
        .clk(clk), .rst_n(rst_n),
        .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .port_wr_p4(port_wr_p4), .port_wr_p6(port_wr_p6), .port_wdata(port_wdata),
        .xaddr(xaddr), .hi_pin_is_addr(hi_pin_is_addr), .ce_pin_en(ce_pin_en),
        .p4_pin_out(p4_pin_out), .p6_pin_out(p6_pin_out), .ce_n(ce_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_wr = 1'b0; sfr_addr = 8'h00;
    endtask

    task automatic unlock();
        sfr_write(KEY, 8'hAA);
        sfr_write(KEY, 8'h55);
    endtask

    task automatic set_cfg(input logic [7:0] d);
        unlock();
        sfr_write(CFG, d);
    endtask

    task automatic read_cfg(output logic [7:0] d);
        sfr_addr = CFG; #1; d = sfr_rdata; sfr_addr = 8'h00; #1;
    endtask

    function automatic int exp_w(input int c);
        if (c == 0) return 15;
        if (c >= 6) return 22;
        return 16 + c;
    endfunction

    function automatic logic [3:0] exp_ce(input int a, input int c);
        int s;
        s = a >> exp_w(c);
        if (s < 4) return ~(4'b0001 << s);
        return 4'hF;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_cfg(rd);
        check("R1 reset read", rd, 8'hFF);
        check("R1 reset hi pins", hi_pin_is_addr, 6'h3F);
        check("R1 reset ce pins", ce_pin_en, 4'hF);
        check("R1/R9 reset p4 drive", p4_pin_out, 8'h0E);
        check("R1/R9 reset p6 drive", p6_pin_out, 2'b00);

        // R2 other address reads zero
        sfr_addr = 8'h93; #1;
        check("R2 other addr read", sfr_rdata, 8'h00);
        sfr_addr = 8'h00;

        // R3 unprotected write ignored
        sfr_write(CFG, 8'h00);
        read_cfg(rd);
        check("R3 write without unlock", rd, 8'hFF);

        // R4 accepted on 4th edge after key, R2 reserved bits
        unlock();
        repeat (3) @(negedge clk);
        sfr_write(CFG, 8'h12);
        read_cfg(rd);
        check("R4 4th edge accepted / R2 reserved", rd, 8'hD2);

        // R4 rejected on 5th edge
        unlock();
        repeat (4) @(negedge clk);
        sfr_write(CFG, 8'h00);
        read_cfg(rd);
        check("R4 5th edge rejected", rd, 8'hD2);

        // R4 interrupted key
        sfr_write(KEY, 8'hAA);
        sfr_write(8'h80, 8'h00);
        sfr_write(KEY, 8'h55);
        sfr_write(CFG, 8'h00);
        read_cfg(rd);
        check("R4 interrupted key rejected", rd, 8'hD2);

        // R5 R6 R7 R8 sweep over all address-pin codes
        for (int c = 0; c < 8; c++) begin
            int w;
            set_cfg(8'((c << 3) | c));
            read_cfg(rd);
            check("R5 readback", rd, 32'(8'hC0 | (c << 3) | c));
            check("R5 hi pin mask", hi_pin_is_addr, (c >= 6) ? 32'h3F : 32'((1 << c) - 1));
            check("R6 ce pin mask", ce_pin_en, (c >= 4) ? 32'hF : 32'((1 << c) - 1));
            w = exp_w(c);
            for (int j = 0; j < 5; j++) begin
                int base;
                base = j << w;
                if (base < (1 << 22)) begin
                    xaddr = 22'(base); #1;
                    check("R7/R8 window start", ce_n, exp_ce(base, c));
                    xaddr = 22'(base + (1 << w) - 1); #1;
                    check("R7/R8 window end", ce_n, exp_ce(base + (1 << w) - 1, c));
                end
            end
            xaddr = 22'h3FFFFF; #1;
            check("R8 top address", ce_n, exp_ce(32'h3FFFFF, c));
        end

        // R7 code 0 uses 32kB windows
        set_cfg(8'h00);
        xaddr = 22'h008000; #1;
        check("R7 32kB boundary", ce_n, 4'b1101);

        // R9 R10 locked pins through port writes
        set_cfg(8'h1A);
        xaddr = 22'h0A0000;
        port_wdata = 8'h00; port_wr_p4 = 1'b1; port_wr_p6 = 1'b1;
        @(negedge clk);
        port_wr_p4 = 1'b0; port_wr_p6 = 1'b0; #1;
        check("R9 mixed p4 drive", p4_pin_out, 8'h21);
        check("R10 p6 unlocked write", p6_pin_out, 2'b00);
        set_cfg(8'h00);
        #1;
        check("R10 locked latches kept", p4_pin_out, 8'h73);

        // R9 R10 high pins on upper port
        set_cfg(8'h38);
        xaddr = 22'h200000;
        port_wdata = 8'hFF; port_wr_p6 = 1'b1;
        @(negedge clk);
        port_wr_p6 = 1'b0; #1;
        check("R9 p6 address drive", p6_pin_out, 2'b10);
        set_cfg(8'h00);
        #1;
        check("R10 p6 locked latch kept", p6_pin_out, 2'b00);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule